// File: doc/BRIEF.md
# Single-Channel DMA Engine with Automatic Reload

This block is one DMA channel that copies 32-bit words from a source address to a destination address over a simple request/grant bus master port. Software programs a base source address, a base destination address and a word count. Each write to a base register also loads its working copy (current source, current destination, current count). The working copies advance as words move. On completion the channel can optionally reload the working copies from the base values and stay armed for the next request.

A transfer starts in one of two ways. In software mode, writing the software-request bit moves the whole block of words back to back. In external mode, an active-low request pin starts the transfer. In normal external mode each falling edge of the pin moves one word. In demand mode the channel keeps the bus and keeps moving words for as long as the pin stays low. A terminal-count flag and a bus-error flag drive one interrupt output. A lock bit holds a bus-lock output for the whole time the channel owns the bus.

Top module: `dma_reload_chan`

## Requirements
- R1: Register indices on `cfg_addr` are: 0 control, 1 base source, 2 base destination, 3 base count, 4 current source (read-only), 5 current destination (read-only), 6 current count (read-only). A write to index 1, 2 or 3 loads both the base register and its working copy. Control bits are: 0 enable, 2:1 mode (00 external, 01 software), 3 demand, 4 software request, 5 lock, 6 auto-reload, 8 terminal count, 9 error.
- R2: Each word is a read at the current source followed by a write of that data to the current destination. Both addresses then rise by 4 and the current count falls by 1.
- R3: With mode 01, enable 1 and a non-zero count, writing 1 to bit 4 moves every remaining word and clears bit 4 on completion. With any other mode value, bit 4 starts nothing.
- R4: With mode 00 and demand 0, each falling edge of `ext_req_n` moves exactly one word, and `bus_req` is dropped afterwards.
- R5: With mode 00 and demand 1, the channel requests the bus while `ext_req_n` is low and keeps it across words. It releases the bus after the word in flight once the pin goes high.
- R6: The terminal-count bit (8) is set by hardware when the count reaches zero. Writing 0 to it clears it; writing 1 leaves it unchanged.
- R7: With auto-reload (bit 6) set, completion reloads the current registers from the base registers and keeps enable at 1. Without it, the current registers keep their final values and enable clears.
- R8: A `bus_err` response on a read or write sets error bit 9, clears enable and stops the channel with the working registers unchanged. Writing 0 to bit 9 clears it.
- R9: `irq` is high exactly when bit 8 or bit 9 is set.
- R10: With lock bit 5 set, `bus_lock` is high for every cycle in which `bus_req` is high. With bit 5 clear, `bus_lock` stays low.
- R11: After reset all registers read 0, and `bus_req`, `bus_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on `cfg_addr`) |
| ext_req_n | input | 1 | Active-low external transfer request (asynchronous) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_lock | output | 1 | Bus lock while owned |
| bus_valid | output | 1 | Access valid, held until ack or error |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address of access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |
| irq | output | 1 | Interrupt |

## Verification
A falling edge on `ext_req_n` reaches the controller through three flops, so `bus_req` rises about three cycles after the pin drops. The bench therefore does not sample at a fixed cycle after an edge. It waits a bounded window and then reads the working registers and the target memory. A word needs a grant cycle plus two handshakes, and `irq` follows the final write acknowledge by one edge. For this reason the bench polls `irq` at negative edges with a timeout before it compares state. Bus lock and bus-request rises are watched on every negative edge by a monitor, so a wrong value in any single cycle is counted.

// File: rtl/dma_pkg.sv
// Shared constants and types for the reload DMA channel.
// Assumes a 3-bit register index and the fixed control bit layout below.
package dma_pkg;
    localparam logic [2:0] RG_CTRL  = 3'd0;
    localparam logic [2:0] RG_BSRC  = 3'd1;
    localparam logic [2:0] RG_BDST  = 3'd2;
    localparam logic [2:0] RG_BCNT  = 3'd3;
    localparam logic [2:0] RG_CSRC  = 3'd4;
    localparam logic [2:0] RG_CDST  = 3'd5;
    localparam logic [2:0] RG_CCNT  = 3'd6;

    localparam int B_EN     = 0;
    localparam int B_MODE   = 1;   // two bits: 2:1
    localparam int B_DEMAND = 3;
    localparam int B_SWREQ  = 4;
    localparam int B_LOCK   = 5;
    localparam int B_AUTO   = 6;
    localparam int B_TC     = 8;
    localparam int B_ERR    = 9;

    localparam logic [1:0] MODE_EXT = 2'b00;
    localparam logic [1:0] MODE_SW  = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } xfer_st_t;
endpackage

// File: rtl/dma_ext_sync.sv
// Brings the asynchronous active-low request into the clock domain.
// Gives a level (low = active) and a one-cycle pulse on each falling edge.
// Assumes the pin is idle high; flops reset to the idle level.
module dma_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req_n,
    output logic ext_active,
    output logic ext_fall
);
    logic s1_q, s2_q, s3_q;

    // Two-flop synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= ext_req_n;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign ext_active = ~s2_q;
    assign ext_fall   = s3_q & ~s2_q;
endmodule

// File: rtl/dma_chan_regs.sv
// Control/status, base and working registers of the channel.
// Hardware events (word step, completion, error) take priority over a
// software write in the same cycle. Assumes AW <= DW and CW <= DW.
module dma_chan_regs
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          step_in,
    input  logic          done_in,
    input  logic          err_in,
    output logic          en_o,
    output logic [1:0]    mode_o,
    output logic          demand_o,
    output logic          swreq_o,
    output logic          lock_o,
    output logic          err_o,
    output logic          tc_o,
    output logic [AW-1:0] cur_src_o,
    output logic [AW-1:0] cur_dst_o,
    output logic [CW-1:0] cur_cnt_o
);
    localparam int WB = DW / 8;

    logic          en_q, demand_q, swreq_q, lock_q, auto_q, tc_q, err_q;
    logic [1:0]    mode_q;
    logic [AW-1:0] base_src_q, base_dst_q, cur_src_q, cur_dst_q;
    logic [CW-1:0] base_cnt_q, cur_cnt_q;
    logic          wr_ctrl;

    assign wr_ctrl = cfg_we && (cfg_addr == RG_CTRL);

    // Register update: software write first, hardware events override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; demand_q <= 1'b0; swreq_q <= 1'b0; lock_q <= 1'b0;
            auto_q <= 1'b0; tc_q <= 1'b0; err_q <= 1'b0; mode_q <= 2'b00;
            base_src_q <= '0; base_dst_q <= '0; base_cnt_q <= '0;
            cur_src_q  <= '0; cur_dst_q  <= '0; cur_cnt_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q     <= cfg_wdata[B_EN];
                mode_q   <= cfg_wdata[B_MODE+1:B_MODE];
                demand_q <= cfg_wdata[B_DEMAND];
                swreq_q  <= cfg_wdata[B_SWREQ];
                lock_q   <= cfg_wdata[B_LOCK];
                auto_q   <= cfg_wdata[B_AUTO];
                tc_q     <= tc_q & cfg_wdata[B_TC];
                err_q    <= err_q & cfg_wdata[B_ERR];
            end
            if (cfg_we && cfg_addr == RG_BSRC) begin
                base_src_q <= cfg_wdata[AW-1:0];
                cur_src_q  <= cfg_wdata[AW-1:0];
            end
            if (cfg_we && cfg_addr == RG_BDST) begin
                base_dst_q <= cfg_wdata[AW-1:0];
                cur_dst_q  <= cfg_wdata[AW-1:0];
            end
            if (cfg_we && cfg_addr == RG_BCNT) begin
                base_cnt_q <= cfg_wdata[CW-1:0];
                cur_cnt_q  <= cfg_wdata[CW-1:0];
            end
            if (step_in) begin
                cur_src_q <= cur_src_q + AW'(WB);
                cur_dst_q <= cur_dst_q + AW'(WB);
                cur_cnt_q <= cur_cnt_q - 1'b1;
            end
            if (done_in) begin
                tc_q    <= 1'b1;
                swreq_q <= 1'b0;
                if (auto_q) begin
                    cur_src_q <= base_src_q;
                    cur_dst_q <= base_dst_q;
                    cur_cnt_q <= base_cnt_q;
                end else begin
                    en_q <= 1'b0;
                end
            end
            if (err_in) begin
                err_q   <= 1'b1;
                en_q    <= 1'b0;
                swreq_q <= 1'b0;
            end
        end
    end

    // Read multiplexer over the register indices.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RG_CTRL: begin
                cfg_rdata[B_EN]             = en_q;
                cfg_rdata[B_MODE+1:B_MODE]  = mode_q;
                cfg_rdata[B_DEMAND]         = demand_q;
                cfg_rdata[B_SWREQ]          = swreq_q;
                cfg_rdata[B_LOCK]           = lock_q;
                cfg_rdata[B_AUTO]           = auto_q;
                cfg_rdata[B_TC]             = tc_q;
                cfg_rdata[B_ERR]            = err_q;
            end
            RG_BSRC: cfg_rdata = DW'(base_src_q);
            RG_BDST: cfg_rdata = DW'(base_dst_q);
            RG_BCNT: cfg_rdata = DW'(base_cnt_q);
            RG_CSRC: cfg_rdata = DW'(cur_src_q);
            RG_CDST: cfg_rdata = DW'(cur_dst_q);
            RG_CCNT: cfg_rdata = DW'(cur_cnt_q);
            default: cfg_rdata = '0;
        endcase
    end

    assign en_o = en_q;       assign mode_o = mode_q;   assign demand_o = demand_q;
    assign swreq_o = swreq_q; assign lock_o = lock_q;   assign err_o = err_q;
    assign tc_o = tc_q;       assign cur_src_o = cur_src_q;
    assign cur_dst_o = cur_dst_q; assign cur_cnt_o = cur_cnt_q;

    AST_TC_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_q && !done_in |=> !tc_q);  // R6
    AST_TC_WRITE1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q && !(wr_ctrl && !cfg_wdata[B_TC]) |=> tc_q);  // R6
    AST_RELOAD_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_in && auto_q && !cfg_we |=> (cur_cnt_q == base_cnt_q) && en_q);  // R7
    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        step_in && !done_in && !err_in |=> cur_cnt_q == $past(cur_cnt_q) - 1'b1);  // R2
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        err_in |=> err_q && !en_q);  // R8
endmodule

// File: rtl/dma_xfer_fsm.sv
// Transfer sequencer: wins the bus, reads the source word, writes it to the
// destination and decides whether to keep the bus for another word.
// Assumes bus_gnt stays high while bus_req is high, and ack/err are
// single-cycle responses to a held bus_valid.
module dma_xfer_fsm
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    mode,
    input  logic          demand,
    input  logic          swreq,
    input  logic          lock_en,
    input  logic          err_flag,
    input  logic          ext_active,
    input  logic          ext_fall,
    input  logic [AW-1:0] cur_src,
    input  logic [AW-1:0] cur_dst,
    input  logic [CW-1:0] cur_cnt,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_lock,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err,
    output logic          step,
    output logic          done,
    output logic          err_hit
);
    xfer_st_t      st_q;
    logic [DW-1:0] data_q;
    logic          armed, go, last, more;

    assign armed   = en && !err_flag && (cur_cnt != '0);
    assign go      = armed && ((mode == MODE_SW && swreq) ||
                     (mode == MODE_EXT && (demand ? ext_active : ext_fall)));
    assign last    = (cur_cnt == CW'(1));
    assign more    = !last && (mode == MODE_SW || (demand && ext_active));
    assign step    = (st_q == ST_WR) && bus_ack && !bus_err;
    assign done    = step && last;
    assign err_hit = bus_valid && bus_err;

    // State sequencing and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (go) st_q <= ST_REQ;
                ST_REQ:  if (bus_gnt) st_q <= ST_RD;
                ST_RD: begin
                    if (bus_err) st_q <= ST_IDLE;
                    else if (bus_ack) begin
                        data_q <= bus_rdata;
                        st_q   <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (bus_err) st_q <= ST_IDLE;
                    else if (bus_ack) st_q <= more ? ST_RD : ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_req   = (st_q != ST_IDLE);
    assign bus_lock  = lock_en && bus_req;
    assign bus_valid = (st_q == ST_RD) || (st_q == ST_WR);
    assign bus_we    = (st_q == ST_WR);
    assign bus_addr  = (st_q == ST_WR) ? cur_dst : cur_src;
    assign bus_wdata = data_q;

    AST_SINGLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WR) && bus_ack && mode == MODE_EXT && !demand |=> !bus_req);  // R4
    AST_DEMAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        step && !last && mode == MODE_EXT && demand && ext_active
        |=> bus_valid && !bus_we);  // R5
    AST_SW_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) && mode != MODE_SW && mode != MODE_EXT |=> !bus_req);  // R3
endmodule

// File: rtl/dma_reload_chan.sv
// Top of the single DMA channel: register block, request synchronizer and
// transfer sequencer. The interrupt is the OR of the two status flags.
module dma_reload_chan #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          ext_req_n,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_lock,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err,
    output logic          irq
);
    logic          en, demand, swreq, lock_en, err_flag, tc_flag;
    logic [1:0]    mode;
    logic [AW-1:0] cur_src, cur_dst;
    logic [CW-1:0] cur_cnt;
    logic          ext_active, ext_fall, step, done, err_hit;

    dma_chan_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .step_in(step), .done_in(done), .err_in(err_hit),
        .en_o(en), .mode_o(mode), .demand_o(demand), .swreq_o(swreq),
        .lock_o(lock_en), .err_o(err_flag), .tc_o(tc_flag),
        .cur_src_o(cur_src), .cur_dst_o(cur_dst), .cur_cnt_o(cur_cnt)
    );

    dma_ext_sync u_sync (
        .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n),
        .ext_active(ext_active), .ext_fall(ext_fall)
    );

    dma_xfer_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .demand(demand),
        .swreq(swreq), .lock_en(lock_en), .err_flag(err_flag),
        .ext_active(ext_active), .ext_fall(ext_fall),
        .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_lock(bus_lock),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .step(step), .done(done), .err_hit(err_hit)
    );

    assign irq = tc_flag | err_flag;

    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq);  // R9
    AST_LOCK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !lock_en |-> !bus_lock);  // R10
endmodule

// File: tb/dma_reload_chan_bench.sv
module dma_reload_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        ext_req_n = 1'b1;
    logic        bus_req, bus_lock, bus_valid, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = 32'd0;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic        irq;
    logic        bus_gnt;

    int checks = 0, errors = 0, wr_cnt = 0, lock_bad = 0, req_rises = 0;
    logic exp_lock = 1'b0, req_prev = 1'b0, finished = 1'b0;
    logic [31:0] mem [64];

    // Control word fields (R1): en bit0, mode 2:1, demand 3, swreq 4, lock 5, auto 6, tc 8, err 9
    localparam logic [31:0] C_EN = 32'h1, C_SW = 32'h2, C_DEM = 32'h8,
                            C_SWREQ = 32'h10, C_LOCK = 32'h20, C_AUTO = 32'h40,
                            C_TC = 32'h100, C_ERR = 32'h200;

    // Software-mode vectors: {src word idx, dst word idx, count, auto}
    localparam logic [31:0] VEC [4] = '{
        {8'd0, 8'd16, 8'd4, 8'd0},
        {8'd4, 8'd24, 8'd1, 8'd1},
        {8'd8, 8'd32, 8'd6, 8'd1},
        {8'd2, 8'd40, 8'd3, 8'd0}
    };

    always #5 clk = ~clk;

    assign bus_gnt = bus_req;

    dma_reload_chan u_dma_reload_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_req_n(ext_req_n),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_lock(bus_lock),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .irq(irq)
    );

    // Memory model: one-cycle ack, error response at byte address 0xFC.
    always @(posedge clk) begin
        if (bus_valid && !bus_ack && !bus_err) begin
            if (bus_addr[7:0] == 8'hFC) bus_err <= 1'b1;
            else begin
                bus_ack <= 1'b1;
                if (bus_we) begin
                    mem[bus_addr[7:2]] <= bus_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else bus_rdata <= mem[bus_addr[7:2]];
            end
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end
    end

    // Lock and request-rise monitor.
    always @(negedge clk) begin
        if (bus_req && (bus_lock !== exp_lock)) lock_bad <= lock_bad + 1;
        if (bus_req && !req_prev) req_rises <= req_rises + 1;
        req_prev <= bus_req;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic mem_init();
        for (int i = 0; i < 64; i++) mem[i] = (i < 16) ? (32'hA500_0000 + i) : 32'd0;
    endtask

    task automatic wait_irq(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (irq) begin seen = 1'b1; break; end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c;
        logic seen;
        mem_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(3'd0, v); chk(v == 0, "R11 ctrl", v, 0);
        rd(3'd6, v); chk(v == 0, "R11 cur count", v, 0);
        chk(!bus_req && !bus_valid, "R11 bus idle", {30'd0, bus_req, bus_valid}, 0);
        chk(!irq, "R11 irq", {31'd0, irq}, 0);

        // R2 R3 R7 table of software-mode transfers
        for (int k = 0; k < 4; k++) begin
            logic [7:0] s, d, n, au;
            {s, d, n, au} = VEC[k];
            mem_init();
            wr(3'd0, 32'd0);
            wr(3'd1, {22'd0, s, 2'b00});
            wr(3'd2, {22'd0, d, 2'b00});
            wr(3'd3, {24'd0, n});
            wr(3'd0, C_EN | C_SW | C_SWREQ | (au[0] ? C_AUTO : 32'd0));
            wait_irq(seen);
            chk(seen, "R9 irq on completion", {31'd0, seen}, 1);
            for (int j = 0; j < 8; j++) begin
                logic [31:0] e;
                e = (j < int'(n)) ? 32'hA500_0000 + 32'(s) + 32'(j) : 32'd0;
                chk(mem[d + j] == e, "R2 copied word", mem[d + j], e);
            end
            rd(3'd0, c);
            chk(c[8] && !c[4], "R3 tc set swreq cleared", c, C_TC);
            chk(c[0] == au[0], "R7 enable after completion", c, {31'd0, au[0]});
            rd(3'd6, v);
            chk(v == (au[0] ? 32'(n) : 0), "R7 current count", v, au[0] ? 32'(n) : 0);
            rd(3'd4, v);
            chk(v == (au[0] ? 32'(s) * 4 : (32'(s) + 32'(n)) * 4), "R7 current source", v,
                au[0] ? 32'(s) * 4 : (32'(s) + 32'(n)) * 4);
            rd(3'd5, v);
            chk(v == (au[0] ? 32'(d) * 4 : (32'(d) + 32'(n)) * 4), "R2 current destination", v,
                au[0] ? 32'(d) * 4 : (32'(d) + 32'(n)) * 4);
        end

        // R6 writing 1 keeps tc, writing 0 clears it; R9 follows
        wr(3'd0, C_TC);
        rd(3'd0, c); chk(c[8] == 1'b1, "R6 write 1 keeps tc", c, C_TC);
        wr(3'd0, 32'd0);
        rd(3'd0, c); chk(c[8] == 1'b0, "R6 write 0 clears tc", c, 0);
        chk(!irq, "R9 irq low with flags clear", {31'd0, irq}, 0);

        // R3 software request ignored outside software mode
        mem_init();
        wr(3'd1, 32'd0); wr(3'd2, 32'd192); wr(3'd3, 32'd2);
        idle(2);
        req_rises = 0;
        wr(3'd0, C_EN | C_SWREQ | 32'h4);
        idle(30);
        rd(3'd6, v); chk(v == 2, "R3 swreq ignored mode 10 count", v, 2);
        wr(3'd0, C_EN | C_SWREQ);
        idle(30);
        rd(3'd6, v); chk(v == 2, "R3 swreq ignored mode 00 count", v, 2);
        chk(req_rises == 0, "R3 no bus request", req_rises, 0);

        // R4 normal external mode: one word per falling edge
        wr(3'd0, 32'd0);
        wr(3'd3, 32'd3);
        wr(3'd0, C_EN);
        idle(2);
        ext_req_n = 1'b0; idle(4); ext_req_n = 1'b1; idle(30);
        rd(3'd6, v); chk(v == 2, "R4 one word per edge", v, 2);
        chk(mem[48] == 32'hA500_0000 && mem[49] == 0, "R4 single destination word", mem[49], 0);
        chk(!bus_req, "R4 bus released", {31'd0, bus_req}, 0);
        ext_req_n = 1'b0; idle(4); ext_req_n = 1'b1; idle(30);
        rd(3'd6, v); chk(v == 1, "R4 second edge", v, 1);

        // R5 demand mode holds the bus while the pin is low
        mem_init();
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0); wr(3'd2, 32'd192); wr(3'd3, 32'd8);
        wr(3'd0, C_EN | C_DEM);
        idle(2);
        req_rises = 0;
        begin
            int w0;
            w0 = wr_cnt;
            ext_req_n = 1'b0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (wr_cnt == w0 + 3) break;
            end
        end
        ext_req_n = 1'b1;
        idle(30);
        rd(3'd6, v); chk(v >= 3 && v <= 5, "R5 stops after pin release", v, 4);
        chk(req_rises == 1, "R5 bus held across words", req_rises, 1);
        chk(!bus_req && !irq, "R5 released without completion", {30'd0, bus_req, irq}, 0);

        // R10 lock held for whole software transfer
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0); wr(3'd2, 32'd192); wr(3'd3, 32'd3);
        exp_lock = 1'b1; lock_bad = 0;
        wr(3'd0, C_EN | C_SW | C_SWREQ | C_LOCK);
        wait_irq(seen);
        idle(2);
        chk(seen && lock_bad == 0, "R10 lock held", lock_bad, 0);
        exp_lock = 1'b0;
        wr(3'd0, 32'd0);

        // R8 bus error stops the channel; R9 irq from error
        wr(3'd1, 32'h0000_00FC); wr(3'd2, 32'd192); wr(3'd3, 32'd2);
        wr(3'd0, C_EN | C_SW | C_SWREQ);
        wait_irq(seen);
        rd(3'd0, c);
        chk(c[9] && !c[0], "R8 error set enable cleared", c, C_ERR);
        chk(seen, "R9 irq on error", {31'd0, seen}, 1);
        rd(3'd6, v); chk(v == 2, "R8 count unchanged", v, 2);
        wr(3'd0, C_ERR);
        rd(3'd0, c); chk(c[9], "R8 write 1 keeps error", c, C_ERR);
        wr(3'd0, 32'd0);
        rd(3'd0, c); chk(!c[9], "R8 write 0 clears error", c, 0);
        chk(!irq, "R9 irq cleared", {31'd0, irq}, 0);

        // R1 base write loads working copy
        wr(3'd1, 32'h0000_0040);
        rd(3'd4, v); chk(v == 32'h40, "R1 base write loads current", v, 32'h40);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule